// File: doc/BRIEF.md
# Flash Command Sequencer with Unlock Bypass

This block decodes the bus write cycles presented to a flash device into operation requests. In normal mode it accepts the full keyed grammar: every erase opens with a pair of unlock writes, carries an erase setup opcode, repeats the unlock pair and ends with a chip or block erase opcode. The same unlock pair followed by a bypass opcode switches the sequencer into a shortened grammar. In that grammar a program, block erase or chip erase takes only two writes, and a dedicated two-write reset leaves the mode again.

Bypass can also be imposed in hardware. When the supply-pin level input reports the high-voltage level, the sequencer is held in bypass and flags that all blocks are unprotected. Removing that level drops both the flag and the bypass mode, including a bypass that was entered by command. Any write that does not fit the sequence in progress returns the decoder to its idle read state. A read-reset opcode does the same from any state without touching the mode.

Each recognised operation produces a one-cycle request pulse on the clock edge after its final write is sampled. The pulse carries the address and data of that final write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all request outputs are 0, `bypass_mode` is 0 and `unprot_all` is 0.
- R2: An unlock write is data AAh at address 555h, followed by data 55h at address 2AAh. A write with a wrong address or wrong data anywhere in a sequence returns the decoder to idle and produces no request.
- R3: In normal mode, the writes unlock, 80h, unlock, 10h give a one-cycle `req_chip_erase` on the edge after the last write is sampled.
- R4: In normal mode, the writes unlock, 80h, unlock, 30h give a one-cycle `req_blk_erase`, and `req_addr` holds the address of the 30h write.
- R5: In normal mode, the writes unlock, 20h give a one-cycle `req_byp_enter`, and `bypass_mode` is 1 from the same edge.
- R6: In bypass mode, A0h followed by any write gives a one-cycle `req_program`, with `req_addr` and `req_data` taken from the second write.
- R7: In bypass mode, 80h then 30h gives `req_blk_erase` with the address of the 30h write, and 80h then 10h gives `req_chip_erase`.
- R8: Each grammar ignores the other's sequences. In bypass mode the full six-write erase produces no request. In normal mode, unlock, A0h, data produces no program.
- R9: In bypass mode entered by command, 90h then 00h gives a one-cycle `req_byp_exit`, and `bypass_mode` is 0 from the same edge.
- R10: `hv_level` encodes 00 as low, 01 as high and 1x as the high-voltage level. One edge after the high-voltage level is sampled, `bypass_mode` and `unprot_all` are 1. One edge after it is removed, both are 0, even if bypass had been entered by command.
- R11: While the high-voltage level holds, 90h then 00h produces no `req_byp_exit` and `bypass_mode` stays 1.
- R12: A write of F0h in any state returns the decoder to idle without changing `bypass_mode`. This includes the data write of a bypass program.
- R13: A change of the high-voltage level abandons any partial sequence. The next write starts a fresh sequence in the grammar now in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W (12) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| hv_level | input | 2 | Supply-pin level: 00 low, 01 high, 1x high voltage |
| req_program | output | 1 | Program request pulse |
| req_blk_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_byp_enter | output | 1 | Bypass entered by command |
| req_byp_exit | output | 1 | Bypass left by reset sequence |
| req_addr | output | ADDR_W (12) | Address of the request's final write |
| req_data | output | DATA_W (8) | Data of the request's final write |
| bypass_mode | output | 1 | Shortened grammar in force |
| unprot_all | output | 1 | All blocks unprotected by high voltage |

## Verification
The hardest situation to reach is a high-voltage change that lands in the middle of a normal sequence. Here a stale state would read the next write under the wrong grammar. The stimulus stops after two unlock writes, raises the level, and then issues a bypass program. That program must succeed, which it can only do if the partial sequence was dropped. A second hard case is a bypass entered by command and then overlaid by the pin: the bench drops the level and expects bypass to end even though no reset sequence was written.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_SETUP, S_ERA1, S_ERA2,
    S_BP_PROG, S_BP_ERASE, S_BP_RST
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROGRAM, OP_BLK_ERASE, OP_CHIP_ERASE, OP_BYP_ENTER, OP_BYP_EXIT
  } op_e;

  typedef struct packed {
    logic key1;
    logic key2;
    logic setup;
    logic byp;
    logic prog;
    logic chip;
    logic blk;
    logic rst1;
    logic rst2;
    logic rd;
  } cmd_class_t;

  localparam logic [7:0] KEY1_DATA = 8'hAA;
  localparam logic [7:0] KEY2_DATA = 8'h55;
  localparam logic [7:0] OPC_SETUP = 8'h80;
  localparam logic [7:0] OPC_BYP   = 8'h20;
  localparam logic [7:0] OPC_PROG  = 8'hA0;
  localparam logic [7:0] OPC_CHIP  = 8'h10;
  localparam logic [7:0] OPC_BLK   = 8'h30;
  localparam logic [7:0] OPC_RST1  = 8'h90;
  localparam logic [7:0] OPC_RST2  = 8'h00;
  localparam logic [7:0] OPC_READ  = 8'hF0;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 'h2AA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output cmd_class_t        cls
);

  logic       hi_zero;
  logic [7:0] code;

  generate
    if (DATA_W > 8) begin : g_wide
      assign hi_zero = ~|data[DATA_W-1:8];
    end else begin : g_byte
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign code = data[7:0];

  always_comb begin
    cls.key1  = hi_zero && (addr == KEY1_ADDR) && (code == KEY1_DATA);
    cls.key2  = hi_zero && (addr == KEY2_ADDR) && (code == KEY2_DATA);
    cls.setup = hi_zero && (code == OPC_SETUP);
    cls.byp   = hi_zero && (code == OPC_BYP);
    cls.prog  = hi_zero && (code == OPC_PROG);
    cls.chip  = hi_zero && (code == OPC_CHIP);
    cls.blk   = hi_zero && (code == OPC_BLK);
    cls.rst1  = hi_zero && (code == OPC_RST1);
    cls.rst2  = hi_zero && (code == OPC_RST2);
    cls.rd    = hi_zero && (code == OPC_READ);
  end

endmodule

// File: rtl/hv_track.sv
module hv_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hv_level,
  output logic       vid_q,
  output logic       vid_rise,
  output logic       vid_fall
);

  logic vid_now;

  assign vid_now  = hv_level[1];
  assign vid_rise = vid_now & ~vid_q;
  assign vid_fall = ~vid_now & vid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vid_q <= 1'b0;
    else        vid_q <= vid_now;
  end

  a_r10_vid_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hv_level[1]) |-> vid_q);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  cmd_class_t        cls,
  input  logic              vid_q,
  input  logic              vid_rise,
  input  logic              vid_fall,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              byp_q
);

  seq_state_e state_q, state_n;
  op_e        op_n;
  logic       byp_n;
  logic       in_bypass;
  logic       cap_en;

  assign in_bypass = byp_q | vid_q;
  assign cap_en    = (op_n != OP_NONE);

  always_comb begin
    state_n = state_q;
    byp_n   = byp_q;
    op_n    = OP_NONE;
    if (vid_fall) begin
      state_n = S_IDLE;
      byp_n   = 1'b0;
    end else if (vid_rise) begin
      state_n = S_IDLE;
    end else if (wr_en) begin
      state_n = S_IDLE;
      if (cls.rd) begin
        state_n = S_IDLE;
      end else if (!in_bypass) begin
        unique case (state_q)
          S_IDLE:  if (cls.key1) state_n = S_UNL1;
          S_UNL1:  if (cls.key2) state_n = S_UNL2;
          S_UNL2: begin
            if (cls.setup) state_n = S_SETUP;
            else if (cls.byp) begin
              byp_n = 1'b1;
              op_n  = OP_BYP_ENTER;
            end
          end
          S_SETUP: if (cls.key1) state_n = S_ERA1;
          S_ERA1:  if (cls.key2) state_n = S_ERA2;
          S_ERA2: begin
            if (cls.chip)     op_n = OP_CHIP_ERASE;
            else if (cls.blk) op_n = OP_BLK_ERASE;
          end
          default: state_n = S_IDLE;
        endcase
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (cls.prog)       state_n = S_BP_PROG;
            else if (cls.setup) state_n = S_BP_ERASE;
            else if (cls.rst1)  state_n = S_BP_RST;
          end
          S_BP_PROG: op_n = OP_PROGRAM;
          S_BP_ERASE: begin
            if (cls.chip)     op_n = OP_CHIP_ERASE;
            else if (cls.blk) op_n = OP_BLK_ERASE;
          end
          S_BP_RST: begin
            if (cls.rst2 && !vid_q) begin
              byp_n = 1'b0;
              op_n  = OP_BYP_EXIT;
            end
          end
          default: state_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      byp_q   <= 1'b0;
      op_q    <= OP_NONE;
    end else begin
      state_q <= state_n;
      byp_q   <= byp_n;
      op_q    <= op_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  a_r6_prog_needs_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_PROGRAM) |-> $past(in_bypass));

  a_r5_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_BYP_ENTER) |-> (byp_q && !$past(in_bypass)));

  a_r9_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_BYP_EXIT) |-> (!byp_q && $past(byp_q)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        hv_level,
  output logic              req_program,
  output logic              req_blk_erase,
  output logic              req_chip_erase,
  output logic              req_byp_enter,
  output logic              req_byp_exit,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              bypass_mode,
  output logic              unprot_all
);

  cmd_class_t cls;
  op_e        op_q;
  logic       vid_q, vid_rise, vid_fall, byp_q;

  cmd_classify #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)
  ) i_classify (
    .addr(wr_addr), .data(wr_data), .cls(cls)
  );

  hv_track i_hv (
    .clk(clk), .rst_n(rst_n), .hv_level(hv_level),
    .vid_q(vid_q), .vid_rise(vid_rise), .vid_fall(vid_fall)
  );

  seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cls(cls), .vid_q(vid_q), .vid_rise(vid_rise),
    .vid_fall(vid_fall), .op_q(op_q), .addr_q(req_addr),
    .data_q(req_data), .byp_q(byp_q)
  );

  assign req_program    = (op_q == OP_PROGRAM);
  assign req_blk_erase  = (op_q == OP_BLK_ERASE);
  assign req_chip_erase = (op_q == OP_CHIP_ERASE);
  assign req_byp_enter  = (op_q == OP_BYP_ENTER);
  assign req_byp_exit   = (op_q == OP_BYP_EXIT);
  assign bypass_mode    = byp_q | vid_q;
  assign unprot_all     = vid_q;

  a_r10_drop_ends_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unprot_all) |-> !bypass_mode);

  a_r11_no_exit_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_all |-> !req_byp_exit);

  a_r12_read_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_data[7:0]) == 8'hF0 && $past(hv_level[1]) == $past(vid_q))
      |-> (bypass_mode == $past(bypass_mode)));

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int K_NONE = 0, K_PROG = 1, K_BLK = 2, K_CHIP = 3, K_ENT = 4, K_EXIT = 5;

  typedef struct {
    int          kind;
    logic [11:0] a;
    logic [7:0]  d;
    bit          byp;
    bit          unp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  hv_level;
  logic        req_program, req_blk_erase, req_chip_erase, req_byp_enter, req_byp_exit;
  logic [11:0] req_addr;
  logic [7:0]  req_data;
  logic        bypass_mode, unprot_all;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   pend     = 0;
  bit   done     = 0;
  exp_t q[$];

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hv_level(hv_level), .req_program(req_program), .req_blk_erase(req_blk_erase),
    .req_chip_erase(req_chip_erase), .req_byp_enter(req_byp_enter),
    .req_byp_exit(req_byp_exit), .req_addr(req_addr), .req_data(req_data),
    .bypass_mode(bypass_mode), .unprot_all(unprot_all)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] kind_vec(int k);
    logic [4:0] v = '0;
    if (k != K_NONE) v[k-1] = 1'b1;
    return v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per sampled write
  always @(negedge clk) begin
    if (pend && q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e   = q.pop_front();
      got = {req_byp_exit, req_byp_enter, req_chip_erase, req_blk_erase, req_program};
      check(got == kind_vec(e.kind), e.tag, "requests", got, kind_vec(e.kind));
      check(bypass_mode == e.byp && unprot_all == e.unp, e.tag, "mode/unprot",
            {bypass_mode, unprot_all}, {e.byp, e.unp});
      if (e.kind == K_PROG || e.kind == K_BLK)
        check(req_addr == e.a, e.tag, "req_addr", req_addr, e.a);
      if (e.kind == K_PROG)
        check(req_data == e.d, e.tag, "req_data", req_data, e.d);
    end
    pend = wr_en;
  end

  task automatic wr(logic [11:0] a, logic [7:0] d, int kind, bit byp, bit unp, string tag);
    exp_t e;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e.kind = kind; e.a = a; e.d = d; e.byp = byp; e.unp = unp; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic unlock(bit byp, bit unp, string tag);
    wr(12'h555, 8'hAA, K_NONE, byp, unp, tag);
    wr(12'h2AA, 8'h55, K_NONE, byp, unp, tag);
  endtask

  task automatic set_hv(logic [1:0] lvl, bit byp, bit unp, string tag);
    @(posedge clk); #1;
    hv_level = lvl;
    @(posedge clk);
    @(negedge clk);
    check(bypass_mode == byp && unprot_all == unp, tag, "hv mode/unprot",
          {bypass_mode, unprot_all}, {byp, unp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; hv_level = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({req_program, req_blk_erase, req_chip_erase, req_byp_enter, req_byp_exit} == 5'b0,
          "R1", "requests", 0, 0);
    check(!bypass_mode && !unprot_all, "R1", "mode/unprot", {bypass_mode, unprot_all}, 0);

    // R3 chip erase, full grammar
    unlock(0, 0, "R3"); wr(12'h555, 8'h80, K_NONE, 0, 0, "R3");
    unlock(0, 0, "R3"); wr(12'h000, 8'h10, K_CHIP, 0, 0, "R3");
    // R4 block erase with address
    unlock(0, 0, "R4"); wr(12'h555, 8'h80, K_NONE, 0, 0, "R4");
    unlock(0, 0, "R4"); wr(12'h7C0, 8'h30, K_BLK, 0, 0, "R4");
    // R2 wrong address, wrong data
    wr(12'h555, 8'hAA, K_NONE, 0, 0, "R2"); wr(12'h2AB, 8'h55, K_NONE, 0, 0, "R2");
    wr(12'h555, 8'h80, K_NONE, 0, 0, "R2"); unlock(0, 0, "R2");
    wr(12'h000, 8'h10, K_NONE, 0, 0, "R2");
    wr(12'h555, 8'hAA, K_NONE, 0, 0, "R2"); wr(12'h2AA, 8'h54, K_NONE, 0, 0, "R2");
    wr(12'h000, 8'h20, K_NONE, 0, 0, "R2");
    // R8 normal-mode program shape is ignored
    unlock(0, 0, "R8"); wr(12'h000, 8'hA0, K_NONE, 0, 0, "R8");
    wr(12'h123, 8'h5A, K_NONE, 0, 0, "R8");
    // R12 read reset in partial sequence
    wr(12'h555, 8'hAA, K_NONE, 0, 0, "R12"); wr(12'h000, 8'hF0, K_NONE, 0, 0, "R12");
    wr(12'h2AA, 8'h55, K_NONE, 0, 0, "R12"); wr(12'h000, 8'h20, K_NONE, 0, 0, "R12");
    // R5 enter bypass by command
    unlock(0, 0, "R5"); wr(12'h000, 8'h20, K_ENT, 1, 0, "R5");
    // R6 bypass program
    wr(12'h000, 8'hA0, K_NONE, 1, 0, "R6"); wr(12'h345, 8'h3C, K_PROG, 1, 0, "R6");
    // R7 bypass erases
    wr(12'h000, 8'h80, K_NONE, 1, 0, "R7"); wr(12'h100, 8'h30, K_BLK, 1, 0, "R7");
    wr(12'h000, 8'h80, K_NONE, 1, 0, "R7"); wr(12'h000, 8'h10, K_CHIP, 1, 0, "R7");
    // R8 full grammar ignored in bypass
    unlock(1, 0, "R8"); wr(12'h555, 8'h80, K_NONE, 1, 0, "R8");
    unlock(1, 0, "R8"); wr(12'h000, 8'h10, K_NONE, 1, 0, "R8");
    // R12 read reset aborts bypass program, mode kept
    wr(12'h000, 8'hA0, K_NONE, 1, 0, "R12"); wr(12'h000, 8'hF0, K_NONE, 1, 0, "R12");
    wr(12'h222, 8'h77, K_NONE, 1, 0, "R12");
    // R9 exit by reset sequence
    wr(12'h000, 8'h90, K_NONE, 1, 0, "R9"); wr(12'h000, 8'h00, K_EXIT, 0, 0, "R9");
    wr(12'h000, 8'hA0, K_NONE, 0, 0, "R9"); wr(12'h345, 8'h3C, K_NONE, 0, 0, "R9");
    // R10 high voltage forces bypass
    set_hv(2'b10, 1, 1, "R10");
    wr(12'h000, 8'hA0, K_NONE, 1, 1, "R10"); wr(12'h010, 8'h99, K_PROG, 1, 1, "R10");
    // R11 reset sequence has no effect under high voltage
    wr(12'h000, 8'h90, K_NONE, 1, 1, "R11"); wr(12'h000, 8'h00, K_NONE, 1, 1, "R11");
    set_hv(2'b01, 0, 0, "R10");
    // R10 drop also ends command-entered bypass
    unlock(0, 0, "R10"); wr(12'h000, 8'h20, K_ENT, 1, 0, "R10");
    set_hv(2'b11, 1, 1, "R10");
    set_hv(2'b00, 0, 0, "R10");
    // R13 level change abandons partial sequence
    unlock(0, 0, "R13");
    set_hv(2'b10, 1, 1, "R13");
    wr(12'h000, 8'hA0, K_NONE, 1, 1, "R13"); wr(12'h0AB, 8'hCD, K_PROG, 1, 1, "R13");
    set_hv(2'b00, 0, 0, "R13");

    repeat (3) @(posedge clk);
    check(q.size() == 0, "R1", "queue drained", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule